// File: doc/BRIEF.md
# SIMD Byte-Lane Permute Unit

This unit rearranges the bytes of vector operands. Each request brings two source vectors (A and B), a table of up to four 64-bit words, the old destination vector, an opcode, an element-size code and an immediate. One cycle later the unit presents one or two rearranged result vectors. The supported operations are:

- extract from a concatenated pair
- element reversal inside 16-, 32- or 64-bit groups
- table lookup, which either zeroes a byte or keeps the old byte when its index is out of range
- 2x2 transpose
- interleave (zip)
- de-interleave (unzip)

A mode bit selects a 128-bit vector or a 64-bit vector. In 64-bit mode only the low eight bytes of each operand are used. Element numbering always starts at the least significant byte.

Every operation reads the same byte pool, which holds A, B, the old destination and the table. Each output byte is a selection from that pool, or zero. The opcode, the size code and the mode work out which pool byte each output byte takes. A request with an illegal combination raises an error flag, and the result registers keep their previous contents.

Top module: `simd_perm`

## Requirements
- R1: While reset is held, and after it is released with no request, `out_valid`, `err`, `res_lo` and `res_hi` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `err` is only ever high together with `out_valid`.
- R3: Extract (op 0): with N = 16 (quad = 1) or N = 8 (quad = 0), result byte i is byte imm+i of the 2N-byte value whose low N bytes come from A and whose high N bytes come from B.
- R4: Extract with quad = 0 and imm ≥ 8 sets `err`.
- R5: Reverse (op 1, 2, 3 for 16-, 32- and 64-bit groups) reverses the element order inside each group of A. The element size is coded 0 = 8, 1 = 16, 2 = 32 bits.
- R6: A reverse whose element size is not smaller than its group, a size code of 3 for reverse, transpose, zip or unzip, or an opcode above 8 sets `err`, and both result ports keep their previous values.
- R7: Table lookup (op 4): each control byte of B indexes the table bytes. `tbl_len` = number of table words minus one, so the table holds 8·(tbl_len+1) bytes. An index at or above that count gives 0.
- R8: Table extension (op 5) works like R7, but an out-of-range index copies the matching byte of the old destination.
- R9: Transpose (op 6): for each element pair 2k, 2k+1, `res_lo` gets A[2k], B[2k] and `res_hi` gets A[2k+1], B[2k+1].
- R10: Zip (op 7): with M elements per vector, the sequence A[0], B[0], A[1], B[1], … fills `res_lo` with its first M elements and `res_hi` with the next M.
- R11: Unzip (op 8): the concatenation A elements then B elements is split so that `res_lo` gets the even-numbered entries and `res_hi` gets the odd-numbered entries.
- R12: With quad = 0 the upper 64 bits of both result ports are zero. Single-result operations (ops 0–5) drive `res_hi` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| size | input | 2 | Element size code |
| quad | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| imm | input | 4 | Extract byte offset |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector / lookup control bytes |
| tbl | input | 256 | Table words, word 0 in the low bits |
| tbl_len | input | 2 | Number of table words minus one |
| old_dst | input | 128 | Previous destination value |
| out_valid | output | 1 | Result valid |
| err | output | 1 | Illegal request flag |
| res_lo | output | 128 | First result vector |
| res_hi | output | 128 | Second result vector |

## Verification
The bench builds the unit with its default parameters: 16 bytes per vector and four table words. This makes both the 64-bit and 128-bit modes reachable, along with every table length from one to four words, every extract offset and every element-size code, including the illegal code 3. Directed requests cover the table-index boundaries at 8, 32 and above, and the corners of every operation. A stream of random requests, mixed with idle cycles, is then compared cycle by cycle against a queue-based reference model.

// File: rtl/simd_perm_pkg.sv
package simd_perm_pkg;

  typedef enum logic [3:0] {
    OP_EXT   = 4'd0,
    OP_REV16 = 4'd1,
    OP_REV32 = 4'd2,
    OP_REV64 = 4'd3,
    OP_TBL   = 4'd4,
    OP_TBX   = 4'd5,
    OP_TRN   = 4'd6,
    OP_ZIP   = 4'd7,
    OP_UZP   = 4'd8
  } perm_op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/simd_perm_legal.sv
module simd_perm_legal
  import simd_perm_pkg::*;
#(
  parameter int VB   = 16,
  parameter int IMMW = $clog2(VB)
) (
  input  logic [3:0]      op,
  input  logic [1:0]      size,
  input  logic            quad,
  input  logic [IMMW-1:0] imm,
  output logic            illegal
);

  localparam int HALF = VB / 2;

  always_comb begin
    illegal = 1'b0;
    case (op)
      OP_EXT:   illegal = !quad && (int'(imm) >= HALF);
      OP_REV16: illegal = (size != SZ_BYTE);
      OP_REV32: illegal = (size == SZ_WORD) || (size == SZ_BAD);
      OP_REV64: illegal = (size == SZ_BAD);
      OP_TBL,
      OP_TBX:   illegal = 1'b0;
      OP_TRN,
      OP_ZIP,
      OP_UZP:   illegal = (size == SZ_BAD);
      default:  illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/simd_perm_route.sv
module simd_perm_route
  import simd_perm_pkg::*;
#(
  parameter int VB    = 16,
  parameter int TREGS = 4,
  parameter int IMMW  = $clog2(VB),
  parameter int LENW  = (TREGS > 1) ? $clog2(TREGS) : 1,
  parameter int POOL  = 3 * VB + 8 * TREGS,
  parameter int SELW  = $clog2(POOL)
) (
  input  logic [3:0]      op,
  input  logic [1:0]      size,
  input  logic            quad,
  input  logic [IMMW-1:0] imm,
  input  logic [LENW-1:0] tbl_len,
  input  logic [VB*8-1:0] ctl,
  output logic [SELW-1:0] sel_o [2*VB],
  output logic [2*VB-1:0] zero_o
);

  localparam int A_BASE = 0;
  localparam int B_BASE = VB;
  localparam int O_BASE = 2 * VB;
  localparam int T_BASE = 3 * VB;

  for (genvar p = 0; p < 2 * VB; p++) begin : g_pos
    localparam int I = p % VB;
    localparam int H = p / VB;

    always_comb begin
      int nb, eb, m, e, byt, g, ge, grp, pos, src, z, c, lim;
      logic [7:0] idx;
      nb  = quad ? VB : VB / 2;
      eb  = 1 << size;
      m   = nb / eb;
      e   = I / eb;
      byt = I % eb;
      g   = 2;
      ge  = 1;
      grp = 0;
      pos = 0;
      src = 0;
      z   = 0;
      c   = 0;
      lim = 8 * (int'(tbl_len) + 1);
      idx = ctl[I*8 +: 8];
      sel_o[p]  = '0;
      zero_o[p] = 1'b1;
      if (I < nb) begin
        case (op)
          OP_EXT: begin
            if (H == 0) begin
              src = int'(imm) + I;
              zero_o[p] = 1'b0;
              sel_o[p]  = SELW'((src < nb) ? (A_BASE + src) : (B_BASE + src - nb));
            end
          end
          OP_REV16, OP_REV32, OP_REV64: begin
            g = (op == OP_REV16) ? 2 : ((op == OP_REV32) ? 4 : 8);
            if (H == 0 && eb < g) begin
              ge  = g / eb;
              grp = e / ge;
              pos = e % ge;
              src = (grp * ge + ge - 1 - pos) * eb + byt;
              zero_o[p] = 1'b0;
              sel_o[p]  = SELW'(A_BASE + src);
            end
          end
          OP_TBL, OP_TBX: begin
            if (H == 0) begin
              if (int'(idx) < lim) begin
                zero_o[p] = 1'b0;
                sel_o[p]  = SELW'(T_BASE + int'(idx));
              end else if (op == OP_TBX) begin
                zero_o[p] = 1'b0;
                sel_o[p]  = SELW'(O_BASE + I);
              end
            end
          end
          OP_TRN: begin
            zero_o[p] = 1'b0;
            if (H == 0)
              sel_o[p] = SELW'((e % 2 == 1) ? (B_BASE + (e - 1) * eb + byt) : (A_BASE + I));
            else
              sel_o[p] = SELW'((e % 2 == 1) ? (B_BASE + I) : (A_BASE + (e + 1) * eb + byt));
          end
          OP_ZIP: begin
            z   = H * m + e;
            src = (z / 2) * eb + byt;
            zero_o[p] = 1'b0;
            sel_o[p]  = SELW'(((z % 2) == 1) ? (B_BASE + src) : (A_BASE + src));
          end
          OP_UZP: begin
            c = 2 * e + H;
            zero_o[p] = 1'b0;
            sel_o[p]  = SELW'((c < m) ? (A_BASE + c * eb + byt) : (B_BASE + (c - m) * eb + byt));
          end
          default: begin
            zero_o[p] = 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/simd_perm_xbar.sv
module simd_perm_xbar #(
  parameter int VB    = 16,
  parameter int TREGS = 4,
  parameter int POOL  = 3 * VB + 8 * TREGS,
  parameter int SELW  = $clog2(POOL),
  parameter int OUTB  = 2 * VB
) (
  input  logic [7:0]      pool  [POOL],
  input  logic [SELW-1:0] sel   [OUTB],
  input  logic [OUTB-1:0] zero,
  output logic [OUTB*8-1:0] dout
);

  for (genvar p = 0; p < OUTB; p++) begin : g_byte
    always_comb begin
      dout[p*8 +: 8] = 8'h00;
      if (!zero[p] && int'(sel[p]) < POOL)
        dout[p*8 +: 8] = pool[sel[p]];
    end
  end

endmodule

// File: rtl/simd_perm.sv
module simd_perm
  import simd_perm_pkg::*;
#(
  parameter int VB    = 16,
  parameter int TREGS = 4,
  parameter int IMMW  = $clog2(VB),
  parameter int LENW  = (TREGS > 1) ? $clog2(TREGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0]           op,
  input  logic [1:0]           size,
  input  logic                 quad,
  input  logic [IMMW-1:0]      imm,
  input  logic [VB*8-1:0]      src_a,
  input  logic [VB*8-1:0]      src_b,
  input  logic [TREGS*64-1:0]  tbl,
  input  logic [LENW-1:0]      tbl_len,
  input  logic [VB*8-1:0]      old_dst,
  output logic                 out_valid,
  output logic                 err,
  output logic [VB*8-1:0]      res_lo,
  output logic [VB*8-1:0]      res_hi
);

  localparam int TBYTES = 8 * TREGS;
  localparam int POOL   = 3 * VB + TBYTES;
  localparam int SELW   = $clog2(POOL);
  localparam int OUTB   = 2 * VB;

  logic [7:0]        pool [POOL];
  logic [SELW-1:0]   sel  [OUTB];
  logic [OUTB-1:0]   zero;
  logic [OUTB*8-1:0] perm;
  logic              illegal;

  always_comb begin
    for (int k = 0; k < VB; k++) begin
      pool[k]          = src_a[k*8 +: 8];
      pool[VB + k]     = src_b[k*8 +: 8];
      pool[2 * VB + k] = old_dst[k*8 +: 8];
    end
    for (int k = 0; k < TBYTES; k++)
      pool[3 * VB + k] = tbl[k*8 +: 8];
  end

  simd_perm_legal #(.VB(VB), .IMMW(IMMW)) u_legal (
    .op      (op),
    .size    (size),
    .quad    (quad),
    .imm     (imm),
    .illegal (illegal)
  );

  simd_perm_route #(
    .VB(VB), .TREGS(TREGS), .IMMW(IMMW), .LENW(LENW), .POOL(POOL), .SELW(SELW)
  ) u_route (
    .op      (op),
    .size    (size),
    .quad    (quad),
    .imm     (imm),
    .tbl_len (tbl_len),
    .ctl     (src_b),
    .sel_o   (sel),
    .zero_o  (zero)
  );

  simd_perm_xbar #(
    .VB(VB), .TREGS(TREGS), .POOL(POOL), .SELW(SELW), .OUTB(OUTB)
  ) u_xbar (
    .pool (pool),
    .sel  (sel),
    .zero (zero),
    .dout (perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      out_valid <= in_valid;
      err       <= in_valid && illegal;
      if (in_valid && !illegal) begin
        res_lo <= perm[VB*8-1:0];
        res_hi <= perm[OUTB*8-1:VB*8];
      end
    end
  end

endmodule

// File: rtl/simd_perm_chk.sv
module simd_perm_chk #(
  parameter int VB   = 16,
  parameter int IMMW = $clog2(VB)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic            quad,
  input logic [IMMW-1:0] imm,
  input logic            out_valid,
  input logic            err,
  input logic [VB*8-1:0] res_lo,
  input logic [VB*8-1:0] res_hi
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> out_valid);

  // R4
  ext_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0 && !quad && int'(imm) >= VB / 2) |=> err);

  // R6
  hold_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(res_lo) && $stable(res_hi)));

  // R12
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !quad) |=> (err || (res_lo[VB*8-1:VB*4] == '0 && res_hi[VB*8-1:VB*4] == '0)));

  // R12
  single_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= 4'd5) |=> (err || res_hi == '0));

endmodule

bind simd_perm simd_perm_chk #(.VB(VB), .IMMW(IMMW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .quad      (quad),
  .imm       (imm),
  .out_valid (out_valid),
  .err       (err),
  .res_lo    (res_lo),
  .res_hi    (res_hi)
);

// File: tb/simd_perm_test.sv
module simd_perm_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   size = '0;
  logic         quad = 1'b0;
  logic [3:0]   imm = '0;
  logic [127:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [255:0] tbl = '0;
  logic [1:0]   tbl_len = '0;
  logic         out_valid, err;
  logic [127:0] res_lo, res_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit           exp_valid = 0, exp_err = 0;
  logic [127:0] exp_lo = '0, exp_hi = '0;
  string        exp_tag = "R1";

  always #4 clk = ~clk;

  simd_perm uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size), .quad(quad),
    .imm(imm), .src_a(src_a), .src_b(src_b), .tbl(tbl), .tbl_len(tbl_len),
    .old_dst(old_dst), .out_valid(out_valid), .err(err), .res_lo(res_lo), .res_hi(res_hi)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] gel(input logic [127:0] v, input int e, input int eb);
    logic [31:0] r = '0;
    for (int k = 0; k < eb; k++) r[k*8 +: 8] = v[(e*eb + k)*8 +: 8];
    return r;
  endfunction

  task automatic pel(inout logic [127:0] v, input int e, input int eb, input logic [31:0] x);
    for (int k = 0; k < eb; k++) v[(e*eb + k)*8 +: 8] = x[k*8 +: 8];
  endtask

  task automatic model(input int o, input int sz, input bit q, input int im,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] od,
                       input logic [255:0] t, input int len,
                       output bit e, output logic [127:0] lo, output logic [127:0] hi);
    int nb = q ? 16 : 8;
    int eb = 1 << sz;
    int m  = nb / eb;
    logic [127:0] mask = q ? {128{1'b1}} : {64'h0, {64{1'b1}}};
    logic [255:0] cat;
    logic [31:0]  qz[$];
    int g, ge, idx;
    e = 0; lo = '0; hi = '0;
    case (o)
      0: begin
        if (im >= nb) e = 1;
        else begin
          cat = (256'(b & mask) << (nb * 8)) | 256'(a & mask);
          cat = cat >> (im * 8);
          lo  = cat[127:0] & mask;
        end
      end
      1, 2, 3: begin
        g = 2 << (o - 1);
        if (sz == 3 || eb >= g) e = 1;
        else begin
          ge = g / eb;
          for (int x = 0; x < m; x++)
            pel(lo, (x / ge) * ge + ge - 1 - (x % ge), eb, gel(a, x, eb));
        end
      end
      4, 5: begin
        for (int i = 0; i < nb; i++) begin
          idx = int'(b[i*8 +: 8]);
          if (idx < 8 * (len + 1)) lo[i*8 +: 8] = t[idx*8 +: 8];
          else if (o == 5)         lo[i*8 +: 8] = od[i*8 +: 8];
        end
      end
      6: begin
        if (sz == 3) e = 1;
        else for (int k = 0; k < m / 2; k++) begin
          pel(lo, 2*k,     eb, gel(a, 2*k, eb));
          pel(lo, 2*k + 1, eb, gel(b, 2*k, eb));
          pel(hi, 2*k,     eb, gel(a, 2*k + 1, eb));
          pel(hi, 2*k + 1, eb, gel(b, 2*k + 1, eb));
        end
      end
      7: begin
        if (sz == 3) e = 1;
        else begin
          for (int j = 0; j < m; j++) begin
            qz.push_back(gel(a, j, eb));
            qz.push_back(gel(b, j, eb));
          end
          for (int j = 0; j < m; j++) begin
            pel(lo, j, eb, qz[j]);
            pel(hi, j, eb, qz[m + j]);
          end
        end
      end
      8: begin
        if (sz == 3) e = 1;
        else begin
          for (int j = 0; j < m; j++) qz.push_back(gel(a, j, eb));
          for (int j = 0; j < m; j++) qz.push_back(gel(b, j, eb));
          for (int j = 0; j < m; j++) begin
            pel(lo, j, eb, qz[2*j]);
            pel(hi, j, eb, qz[2*j + 1]);
          end
        end
      end
      default: e = 1;
    endcase
  endtask

  function automatic string tag_of(input int o, input bit e, input bit q);
    string s;
    if (e) s = (o == 0) ? "R4" : "R6";
    else case (o)
      0: s = "R3";
      1, 2, 3: s = "R5";
      4: s = "R7";
      5: s = "R8";
      6: s = "R9";
      7: s = "R10";
      default: s = "R11";
    endcase
    if (!q && !e) s = {s, "/R12"};
    return s;
  endfunction

  task automatic step(input bit vld, input int o, input int sz, input bit q, input int im,
                      input logic [127:0] a, input logic [127:0] b, input logic [127:0] od,
                      input logic [255:0] t, input int len);
    bit e;
    logic [127:0] lo, hi;
    @(negedge clk);
    chk("R2 out_valid", {127'b0, out_valid}, {127'b0, exp_valid});
    if (exp_valid) begin
      chk({exp_tag, " err"}, {127'b0, err}, {127'b0, exp_err});
      chk({exp_tag, " res_lo"}, res_lo, exp_lo);
      chk({exp_tag, " res_hi"}, res_hi, exp_hi);
    end
    in_valid = vld; op = 4'(o); size = 2'(sz); quad = q; imm = 4'(im);
    src_a = a; src_b = b; old_dst = od; tbl = t; tbl_len = 2'(len);
    if (vld) begin
      model(o, sz, q, im, a, b, od, t, len, e, lo, hi);
      exp_valid = 1; exp_err = e; exp_tag = tag_of(o, e, q);
      if (!e) begin exp_lo = lo; exp_hi = hi; end
    end else begin
      exp_valid = 0; exp_err = 0;
    end
  endtask

  logic [127:0] va, vb, vo, ctl;
  logic [255:0] vt;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      va[i*8 +: 8] = 8'(i);
      vb[i*8 +: 8] = 8'(8'h10 + i);
      vo[i*8 +: 8] = 8'(8'hA0 + i);
    end
    for (int i = 0; i < 32; i++) vt[i*8 +: 8] = 8'(8'h40 + i);
    ctl = {8'd255, 8'd40, 8'd33, 8'd32, 8'd31, 8'd24, 8'd23, 8'd16,
           8'd15, 8'd9, 8'd8, 8'd7, 8'd6, 8'd3, 8'd1, 8'd0};

    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    chk("R1 out_valid", {127'b0, out_valid}, 128'd0);
    chk("R1 err", {127'b0, err}, 128'd0);
    chk("R1 res_lo", res_lo, 128'd0);
    chk("R1 res_hi", res_hi, 128'd0);
    rst = 1'b0;

    // extract
    step(1, 0, 0, 1, 3,  va, vb, vo, vt, 0);
    step(1, 0, 0, 1, 0,  va, vb, vo, vt, 0);
    step(1, 0, 0, 1, 15, va, vb, vo, vt, 0);
    step(1, 0, 0, 0, 5,  va, vb, vo, vt, 0);
    step(1, 0, 0, 0, 9,  va, vb, vo, vt, 0);   // R4
    step(0, 0, 0, 0, 0,  va, vb, vo, vt, 0);
    // reverse, legal and illegal sizes
    for (int o = 1; o <= 3; o++)
      for (int sz = 0; sz <= 3; sz++) begin
        step(1, o, sz, 1, 0, va, vb, vo, vt, 0);
        step(1, o, sz, 0, 0, vb, va, vo, vt, 0);
      end
    // table lookup / extension across lengths
    for (int len = 0; len < 4; len++) begin
      step(1, 4, 0, 1, 0, va, ctl, vo, vt, len);
      step(1, 5, 0, 1, 0, va, ctl, vo, vt, len);
      step(1, 5, 0, 0, 0, va, ctl, vo, vt, len);
    end
    // transpose, zip, unzip
    for (int o = 6; o <= 8; o++)
      for (int sz = 0; sz <= 3; sz++) begin
        step(1, o, sz, 1, 0, va, vb, vo, vt, 0);
        step(1, o, sz, 0, 0, va, vb, vo, vt, 0);
      end
    step(1, 9,  0, 1, 0, va, vb, vo, vt, 0);   // R6 undefined opcode
    step(1, 15, 1, 1, 0, va, vb, vo, vt, 0);
    step(0, 0, 0, 0, 0, va, vb, vo, vt, 0);

    for (int n = 0; n < 500; n++) begin
      logic [127:0] ra, rb, ro;
      logic [255:0] rt;
      int o = $urandom_range(0, 9);
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      ro = {$urandom, $urandom, $urandom, $urandom};
      rt = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (o == 4 || o == 5)
        for (int i = 0; i < 16; i++) rb[i*8 +: 8] = 8'($urandom_range(0, 40));
      step($urandom_range(0, 3) != 0, o, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           $urandom_range(0, 15), ra, rb, ro, rt, $urandom_range(0, 3));
    end
    step(0, 0, 0, 0, 0, va, vb, vo, vt, 0);
    step(0, 0, 0, 0, 0, va, vb, vo, vt, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule